// File: doc/BRIEF.md
# Four-Port Addressed Cell Transmit Slave

This block sits on the physical-layer side of a 16-bit multi-PHY cell bus and receives outbound cells for four ports. The ATM-layer master puts a port address on a shared 5-bit address bus. In every cycle the block answers on a cell-available line. If the address matches one of the four programmed port addresses, the line reports whether that port's transmit FIFO can take a whole cell. If no port matches, the line is released to high impedance, which lets several slaves share it.

To send a cell, the master leaves the target address on the bus for one cycle and then pulls the active-low enable. The block latches that port and holds it until the 27th word of the cell has been written, even across pauses in enable. Each word is checked for odd parity. A mismatch only raises a sticky per-port flag and never alters or drops data. Words are staged in the port FIFO and become readable only once a whole, well-framed cell has arrived. Each port also drives an active-low activity LED from a down-counter, which the start-of-cell marker loads.

On the line side, the cell FIFOs are drained one word at a time through a per-port pop strobe.

Top module: `cbt_tx_slave`

## Requirements
- R1: When `tx_addr` equals a port's programmed address, `tx_clav_oe` is 1 in the same cycle and `tx_clav` is 1 exactly when that port's FIFO has at least 27 free words. Staged words of an unfinished cell count as used.
- R2: When `tx_addr` matches none of the programmed addresses, `tx_clav_oe` is 0 and `tx_clav` is high impedance.
- R3: The port taken for a cell is the one whose address was on `tx_addr` in the cycle before `tx_en_n` went low. That choice is held, through pauses in enable and any address changes, until the cell's 27th word is written.
- R4: A word is taken only in a cycle with `tx_en_n` low and a port selected. A cell becomes readable (`rd_avail`) on the clock edge that writes its 27th word, and not earlier.
- R5: A word with `tx_soc` = 1 arriving at any position other than the first discards the partial cell already staged, and that word becomes word 1 of a new cell.
- R6: A word without `tx_soc` that arrives where a cell's first word is expected is dropped.
- R7: Parity is good when the XOR of the 16 data bits and `tx_parity` is 1. A bad word sets `perr_flag[p]` at the next edge only if `perr_en[p]` is 1. The word is stored unchanged either way.
- R8: `perr_flag[p]` stays set until a cycle with `perr_clr[p]` = 1, after which it reads 0.
- R9: `led_n[p]` goes low on the edge that takes a start-of-cell word for port p and stays low for exactly 223 cycles. A new start-of-cell for that port restarts the 223-cycle count.
- R10: A cell whose port had fewer than 27 free words when it was selected is discarded entirely. Earlier cells in that FIFO are unaffected.
- R11: Each port's FIFO returns words in arrival order. `rd_data` shows the oldest word, and `rd_pop` removes it on the next edge.
- R12: After reset all LEDs are high (off), all error flags are 0 and all FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the LED time base |
| rst | input | 1 | Synchronous active-high reset |
| port_addr_cfg | input | 20 | Programmed 5-bit addresses, port p in bits [5p+4:5p] |
| tx_addr | input | 5 | Poll and select address |
| tx_en_n | input | 1 | Active-low word-valid from the master |
| tx_data | input | 16 | Cell word |
| tx_parity | input | 1 | Odd parity bit for `tx_data` |
| tx_soc | input | 1 | Marks the first word of a cell |
| tx_clav | output | 1 | Room for a full cell at the addressed port; Z when unaddressed |
| tx_clav_oe | output | 1 | 1 while `tx_clav` is driven |
| perr_en | input | 4 | Per-port parity-error enable |
| perr_clr | input | 4 | Per-port write-one-to-clear strobe |
| perr_flag | output | 4 | Sticky per-port parity-error flags |
| led_n | output | 4 | Active-low activity LEDs |
| rd_pop | input | 4 | Per-port FIFO pop strobe |
| rd_data | output | 64 | Per-port head word, port p in bits [16p+15:16p] |
| rd_avail | output | 4 | Per-port: a committed word is readable |

## Verification
Cell-available is combinational and has no latency. The bench drives `tx_addr` at a falling edge and samples `tx_clav` and `tx_clav_oe` 1 ns later within the same cycle. Readability of a cell, error flags and the start of an LED pulse all appear one edge after the word that causes them, so they are checked at the falling edge right after the task that sends the last word returns. Popped words come one per edge and are compared at each falling edge before the next pop takes effect. LED pulse lengths are counted at rising edges and compared with 223, or with the spacing of the two start-of-cell edges plus 223.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    localparam int WORD_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int CELL_WORDS = 27;
    localparam int IDX_W      = $clog2(CELL_WORDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] paddr_t;

    // One bus transfer as sampled at the edge
    typedef struct packed {
        logic  soc;
        logic  par;
        word_t data;
    } xfer_t;

    // What the sequencer does with an incoming word
    typedef enum logic [1:0] {
        W_DROP    = 2'd0,   // stray word where a cell must start
        W_NEXT    = 2'd1,   // ordinary body word
        W_RESTART = 2'd2,   // start marker: (re)open a cell at this word
        W_LAST    = 2'd3    // final word: commit the cell
    } wop_e;

    function automatic logic odd_ok(input word_t d, input logic p);
        return ^{d, p};
    endfunction

    function automatic wop_e classify(input logic soc, input logic [IDX_W-1:0] pos);
        if (soc)
            return W_RESTART;
        else if (pos == '0)
            return W_DROP;
        else if (pos == IDX_W'(CELL_WORDS - 1))
            return W_LAST;
        else
            return W_NEXT;
    endfunction

endpackage

// File: rtl/cbt_addr_match.sv
module cbt_addr_match
    import cbt_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  paddr_t            addr,
    input  logic [N*ADDR_W-1:0] cfg,
    output logic              hit,
    output logic [IW-1:0]     idx
);

    logic [N-1:0] eq;

    generate
        for (genvar p = 0; p < N; p++) begin : g_eq
            assign eq[p] = (cfg[p*ADDR_W +: ADDR_W] == addr);
        end
    endgenerate

    // lowest-numbered matching port wins
    always_comb begin
        hit = |eq;
        idx = '0;
        for (int p = N - 1; p >= 0; p--) begin
            if (eq[p]) idx = IW'(p);
        end
    end

endmodule

// File: rtl/cbt_port_fifo.sv
module cbt_port_fifo
    import cbt_pkg::*;
#(
    parameter int DEPTH = 54
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  logic  restart,
    input  logic  commit,
    input  word_t wr_data,
    input  logic  pop,
    output word_t head,
    output logic  avail,
    output logic  room
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    word_t         mem [DEPTH];
    logic [PW-1:0] rd_ptr, cmt_ptr, wr_ptr;
    logic [CW-1:0] n_cmt, n_part;

    function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    logic [PW-1:0] wr_base, wr_next;
    logic [CW-1:0] part_base, add_n;
    logic          do_pop;

    // a restart throws away staged words by rewinding to the commit point
    assign wr_base   = restart ? cmt_ptr : wr_ptr;
    assign wr_next   = inc(wr_base);
    assign part_base = restart ? '0 : n_part;
    assign add_n     = (wr && commit) ? part_base + CW'(1) : '0;
    assign avail     = (n_cmt != '0);
    assign do_pop    = pop && avail;
    assign head      = mem[rd_ptr];
    assign room      = (int'(n_cmt) + int'(n_part) + CELL_WORDS) <= DEPTH;

    always_ff @(posedge clk) begin
        if (wr) mem[wr_base] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr  <= '0;
            cmt_ptr <= '0;
            wr_ptr  <= '0;
            n_cmt   <= '0;
            n_part  <= '0;
        end else begin
            if (wr) begin
                wr_ptr <= wr_next;
                if (commit) begin
                    cmt_ptr <= wr_next;
                    n_part  <= '0;
                end else begin
                    n_part  <= part_base + CW'(1);
                end
            end
            if (do_pop) rd_ptr <= inc(rd_ptr);
            n_cmt <= n_cmt + add_n - CW'(do_pop);
        end
    end

endmodule

// File: rtl/cbt_led_timer.sv
module cbt_led_timer #(
    parameter int CYCLES = 223
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic led_n
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign led_n = (cnt == '0);

endmodule

// File: rtl/cbt_tx_slave.sv
module cbt_tx_slave
    import cbt_pkg::*;
#(
    parameter int N_PORTS        = 4,
    parameter int CELLS_PER_FIFO = 2,
    parameter int LED_CYCLES     = 223
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_PORTS*ADDR_W-1:0] port_addr_cfg,
    input  logic [ADDR_W-1:0]         tx_addr,
    input  logic                      tx_en_n,
    input  logic [WORD_W-1:0]         tx_data,
    input  logic                      tx_parity,
    input  logic                      tx_soc,
    output logic                      tx_clav,
    output logic                      tx_clav_oe,
    input  logic [N_PORTS-1:0]        perr_en,
    input  logic [N_PORTS-1:0]        perr_clr,
    output logic [N_PORTS-1:0]        perr_flag,
    output logic [N_PORTS-1:0]        led_n,
    input  logic [N_PORTS-1:0]        rd_pop,
    output logic [N_PORTS*WORD_W-1:0] rd_data,
    output logic [N_PORTS-1:0]        rd_avail
);

    localparam int FIFO_DEPTH = CELLS_PER_FIFO * CELL_WORDS;
    localparam int PSEL_W     = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    // ---------------- polling ----------------
    logic              live_hit;
    logic [PSEL_W-1:0] live_idx;
    logic [N_PORTS-1:0] room;

    cbt_addr_match #(.N(N_PORTS), .IW(PSEL_W)) u_live (
        .addr (tx_addr),
        .cfg  (port_addr_cfg),
        .hit  (live_hit),
        .idx  (live_idx)
    );

    assign tx_clav_oe = live_hit;
    assign tx_clav    = live_hit ? room[live_idx] : 1'bz;

    // ---------------- selection and word sequencing ----------------
    xfer_t             w;
    paddr_t            addr_q;
    logic              en_q, en_act, start;
    logic              busy, sel_ok;
    logic [PSEL_W-1:0] sel_port;
    logic [IDX_W-1:0]  pos;
    logic              q_hit;
    logic [PSEL_W-1:0] q_idx;
    logic              cur_valid, cur_ok, xfer, par_bad;
    logic [PSEL_W-1:0] cur_port;
    wop_e              op;

    assign w = '{soc: tx_soc, par: tx_parity, data: tx_data};

    cbt_addr_match #(.N(N_PORTS), .IW(PSEL_W)) u_sel (
        .addr (addr_q),
        .cfg  (port_addr_cfg),
        .hit  (q_hit),
        .idx  (q_idx)
    );

    assign en_act    = !tx_en_n;
    assign start     = en_act && !en_q && !busy;
    assign cur_valid = busy || (start && q_hit);
    assign cur_port  = busy ? sel_port : q_idx;
    assign cur_ok    = busy ? sel_ok : room[q_idx];
    assign xfer      = en_act && cur_valid;
    assign op        = classify(w.soc, pos);
    assign par_bad   = !odd_ok(w.data, w.par);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            en_q     <= 1'b0;
            busy     <= 1'b0;
            sel_ok   <= 1'b0;
            sel_port <= '0;
            pos      <= '0;
        end else begin
            addr_q <= tx_addr;
            en_q   <= en_act;
            if (start && q_hit) begin
                busy     <= 1'b1;
                sel_port <= q_idx;
                sel_ok   <= room[q_idx];
            end
            if (xfer) begin
                unique case (op)
                    W_RESTART: pos <= IDX_W'(1);
                    W_NEXT:    pos <= pos + IDX_W'(1);
                    W_LAST: begin
                        pos  <= '0;
                        busy <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- per-port resources ----------------
    logic [N_PORTS-1:0] port_sel, wr_vec, led_go;

    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_port
            logic flag_q;

            assign port_sel[p] = xfer && (cur_port == PSEL_W'(p));
            assign wr_vec[p]   = port_sel[p] && cur_ok && (op != W_DROP);
            assign led_go[p]   = port_sel[p] && w.soc;

            cbt_port_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
                .clk     (clk),
                .rst     (rst),
                .wr      (wr_vec[p]),
                .restart (op == W_RESTART),
                .commit  (op == W_LAST),
                .wr_data (w.data),
                .pop     (rd_pop[p]),
                .head    (rd_data[p*WORD_W +: WORD_W]),
                .avail   (rd_avail[p]),
                .room    (room[p])
            );

            cbt_led_timer #(.CYCLES(LED_CYCLES)) u_led (
                .clk   (clk),
                .rst   (rst),
                .start (led_go[p]),
                .led_n (led_n[p])
            );

            always_ff @(posedge clk) begin
                if (rst)
                    flag_q <= 1'b0;
                else if (port_sel[p] && par_bad && perr_en[p])
                    flag_q <= 1'b1;
                else if (perr_clr[p])
                    flag_q <= 1'b0;
            end
            assign perr_flag[p] = flag_q;
        end
    endgenerate

endmodule

// File: rtl/cbt_tx_slave_chk.sv
module cbt_tx_slave_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         tx_en_n,
    input logic [N-1:0] port_sel,
    input logic [N-1:0] wr_vec,
    input logic [N-1:0] led_go,
    input logic         par_bad,
    input logic [N-1:0] perr_en,
    input logic [N-1:0] perr_clr,
    input logic [N-1:0] perr_flag,
    input logic [N-1:0] led_n,
    input logic [N-1:0] rd_pop,
    input logic [N-1:0] rd_avail
);

    // R4
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        tx_en_n |-> (wr_vec == '0));

    // R3
    single_port_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_sel));

    generate
        for (genvar p = 0; p < N; p++) begin : g_chk
            // R7
            perr_set_chk: assert property (@(posedge clk) disable iff (rst)
                (port_sel[p] && par_bad && perr_en[p]) |=> perr_flag[p]);

            // R8
            perr_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (perr_flag[p] && !perr_clr[p]) |=> perr_flag[p]);

            // R8
            perr_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (perr_clr[p] && !(port_sel[p] && par_bad && perr_en[p])) |=> !perr_flag[p]);

            // R9
            led_on_chk: assert property (@(posedge clk) disable iff (rst)
                led_go[p] |=> !led_n[p]);

            // R11
            avail_drop_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(rd_avail[p]) |-> $past(rd_pop[p]));
        end
    endgenerate

endmodule

bind cbt_tx_slave cbt_tx_slave_chk #(.N(N_PORTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_en_n   (tx_en_n),
    .port_sel  (port_sel),
    .wr_vec    (wr_vec),
    .led_go    (led_go),
    .par_bad   (par_bad),
    .perr_en   (perr_en),
    .perr_clr  (perr_clr),
    .perr_flag (perr_flag),
    .led_n     (led_n),
    .rd_pop    (rd_pop),
    .rd_avail  (rd_avail)
);

// File: tb/tb_cbt_tx_slave.sv
module tb_cbt_tx_slave;

    localparam logic [4:0] A_P0 = 5'd3;
    localparam logic [4:0] A_P1 = 5'd7;
    localparam logic [4:0] A_P2 = 5'd12;
    localparam logic [4:0] A_P3 = 5'd31;
    localparam logic [4:0] A_IDLE = 5'd20;

    // {address, expected oe, expected clav} with all FIFOs empty
    localparam logic [6:0] CLAV_VEC [8] = '{
        {5'd3,  1'b1, 1'b1},
        {5'd7,  1'b1, 1'b1},
        {5'd12, 1'b1, 1'b1},
        {5'd31, 1'b1, 1'b1},
        {5'd0,  1'b0, 1'b0},
        {5'd20, 1'b0, 1'b0},
        {5'd4,  1'b0, 1'b0},
        {5'd30, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] port_addr_cfg = {A_P3, A_P2, A_P1, A_P0};
    logic [4:0]  tx_addr = A_IDLE;
    logic        tx_en_n = 1'b1;
    logic [15:0] tx_data = '0;
    logic        tx_parity = 1'b1;
    logic        tx_soc = 1'b0;
    logic        tx_clav, tx_clav_oe;
    logic [3:0]  perr_en = '0;
    logic [3:0]  perr_clr = '0;
    logic [3:0]  perr_flag, led_n;
    logic [3:0]  rd_pop = '0;
    logic [63:0] rd_data;
    logic [3:0]  rd_avail;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int soc_cyc = 0;
    int low_cnt [4] = '{0, 0, 0, 0};

    always #2.5 clk = ~clk;

    cbt_tx_slave dut (
        .clk(clk), .rst(rst), .port_addr_cfg(port_addr_cfg),
        .tx_addr(tx_addr), .tx_en_n(tx_en_n), .tx_data(tx_data),
        .tx_parity(tx_parity), .tx_soc(tx_soc),
        .tx_clav(tx_clav), .tx_clav_oe(tx_clav_oe),
        .perr_en(perr_en), .perr_clr(perr_clr), .perr_flag(perr_flag),
        .led_n(led_n), .rd_pop(rd_pop), .rd_data(rd_data), .rd_avail(rd_avail)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            for (int p = 0; p < 4; p++)
                if (led_n[p] === 1'b0) low_cnt[p] <= low_cnt[p] + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tx_en_n = 1'b1;
        tx_soc = 1'b0;
        tx_addr = A_IDLE;
        rd_pop = '0;
        perr_clr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_cell(input logic [4:0] a_sel, input logic [4:0] a_run,
                             input logic [15:0] base, input int n,
                             input int soc_a, input int soc_b,
                             input int bad_k, input int pause_at);
        logic [15:0] d;
        @(negedge clk);
        tx_addr = a_sel;
        tx_en_n = 1'b1;
        tx_soc  = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (k == pause_at) begin
                repeat (3) begin
                    @(negedge clk);
                    tx_en_n = 1'b1;
                    tx_soc  = 1'b0;
                    tx_addr = A_P2;
                end
            end
            @(negedge clk);
            d = base + 16'(k);
            tx_addr   = a_run;
            tx_en_n   = 1'b0;
            tx_data   = d;
            tx_soc    = (k == soc_a) || (k == soc_b);
            tx_parity = (k == bad_k) ? (^d) : ~(^d);
            if (tx_soc) soc_cyc = cyc;
        end
        @(negedge clk);
        tx_en_n = 1'b1;
        tx_soc  = 1'b0;
        tx_addr = A_IDLE;
    endtask

    task automatic pop_expect(input int p, input logic [15:0] base, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(req, 32'(rd_data[p*16 +: 16]), 32'(base + 16'(k)));
            rd_pop[p] = 1'b1;
        end
        @(negedge clk);
        rd_pop[p] = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int s1, s2, base_cnt;
        do_reset();

        // R12 reset state
        @(negedge clk);
        chk("R12 led", 32'(led_n), 32'hF);
        chk("R12 perr", 32'(perr_flag), 32'h0);
        chk("R12 avail", 32'(rd_avail), 32'h0);

        // R1 / R2 polling table
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            tx_addr = CLAV_VEC[i][6:2];
            #1;
            chk("R2 oe", 32'(tx_clav_oe), 32'(CLAV_VEC[i][1]));
            if (CLAV_VEC[i][1]) chk("R1 clav", 32'(tx_clav), 32'(CLAV_VEC[i][0]));
        end

        // R4 / R11 / R9 basic cell to port 1
        base_cnt = low_cnt[1];
        send_cell(A_P1, A_P1, 16'h1000, 27, 0, -1, -1, -1);
        chk("R4 avail p1", 32'(rd_avail), 32'h2);
        pop_expect(1, 16'h1000, 27, "R11 order");
        chk("R11 drained", 32'(rd_avail[1]), 32'h0);
        repeat (250) @(negedge clk);
        chk("R9 led length", 32'(low_cnt[1] - base_cnt), 32'd223);

        // R9 restart on a second start-of-cell
        base_cnt = low_cnt[2];
        send_cell(A_P2, A_P2, 16'h2000, 27, 0, -1, -1, -1);
        s1 = soc_cyc;
        repeat (40) @(negedge clk);
        send_cell(A_P2, A_P2, 16'h2100, 27, 0, -1, -1, -1);
        s2 = soc_cyc;
        repeat (300) @(negedge clk);
        chk("R9 led restart", 32'(low_cnt[2] - base_cnt), 32'(s2 - s1 + 223));

        // R7 / R8 parity
        do_reset();
        perr_en = 4'b0101;
        send_cell(A_P2, A_P2, 16'h3000, 27, 0, -1, 5, -1);
        chk("R7 flag set", 32'(perr_flag[2]), 32'h1);
        send_cell(A_P1, A_P1, 16'h3100, 27, 0, -1, 8, -1);
        chk("R7 flag masked", 32'(perr_flag[1]), 32'h0);
        pop_expect(2, 16'h3000, 27, "R7 data kept");
        chk("R8 sticky", 32'(perr_flag[2]), 32'h1);
        perr_clr = 4'b0100;
        @(negedge clk);
        perr_clr = 4'b0000;
        chk("R8 cleared", 32'(perr_flag[2]), 32'h0);

        // R3 selection from prior cycle, held through a pause
        do_reset();
        send_cell(A_P1, A_P2, 16'h4000, 27, 0, -1, -1, 10);
        chk("R3 port1 got cell", 32'(rd_avail[1]), 32'h1);
        chk("R3 port2 empty", 32'(rd_avail[2]), 32'h0);
        pop_expect(1, 16'h4000, 27, "R3 data");

        // R5 misplaced start-of-cell
        send_cell(A_P3, A_P3, 16'h5000, 31, 0, 4, -1, -1);
        pop_expect(3, 16'h5004, 27, "R5 restart");
        chk("R5 only one cell", 32'(rd_avail[3]), 32'h0);

        // R6 stray words before start-of-cell
        send_cell(A_P3, A_P3, 16'h6000, 30, 3, -1, -1, -1);
        pop_expect(3, 16'h6003, 27, "R6 drop");
        chk("R6 only one cell", 32'(rd_avail[3]), 32'h0);

        // R1 / R10 space accounting
        send_cell(A_P0, A_P0, 16'h7000, 27, 0, -1, -1, -1);
        @(negedge clk);
        tx_addr = A_P0;
        #1;
        chk("R1 room after one", 32'(tx_clav), 32'h1);
        send_cell(A_P0, A_P0, 16'h7100, 27, 0, -1, -1, -1);
        @(negedge clk);
        tx_addr = A_P0;
        #1;
        chk("R1 full oe", 32'(tx_clav_oe), 32'h1);
        chk("R1 full", 32'(tx_clav), 32'h0);
        send_cell(A_P0, A_P0, 16'h7200, 27, 0, -1, -1, -1);
        pop_expect(0, 16'h7000, 27, "R10 first");
        pop_expect(0, 16'h7100, 27, "R10 second");
        chk("R10 third dropped", 32'(rd_avail[0]), 32'h0);

        finish_run();
    end

endmodule